// File: doc/BRIEF.md
# GMII Transmit Control Encoder

This block sits on the MAC side of a gigabit media-independent link and turns a framed byte stream into the three transmit signals a PHY samples on every 125 MHz transmit clock edge: an enable strobe, an error strobe and an 8-bit data bus. A frame is offered one byte per cycle with a start marker on its first byte and an end marker on its last. Preamble, delimiter and frame check bytes are already part of that stream.

Alongside the stream, three request inputs ask for sideband codes. The first flags the byte of the current cycle for error propagation. The second asks for carrier extension right after a frame ends. The third turns that extension into an extension-error code. The encoder drives only the legal strobe and data combinations: idle, normal data, data with error, carrier extend and carrier extend error. It never drives a reserved one. All outputs are registered, so each cycle's inputs appear on the pins one clock later. A sticky flag records error requests that came in while no frame byte was being sent.

Top module: `gmii_tx_encoder`

## Requirements
- R1: While reset is high, and after the first clock edge with reset high, enable, error, data and the sticky flag are all 0.
- R2: A byte accepted as part of a frame with the error request low appears one clock later as enable 1, error 0 and data equal to the byte.
- R3: A frame starts only on a cycle where valid and start are both high outside a frame. A valid byte without start outside a frame is ignored, and the output stays idle.
- R4: Enable stays high on every cycle from the start byte through the end byte. A cycle inside a frame with valid low is sent as enable 1, error 1, data 0x00.
- R5: A frame byte with the error request high is sent as enable 1, error 1 and the byte unchanged.
- R6: When no byte, gap or extension is sent, the outputs are enable 0, error 0 and data 0x00.
- R7: An extension request on the cycle directly after the end byte produces enable 0, error 1, data 0x0F. The extension repeats on every following cycle that the request stays high and ends on the first cycle it is low.
- R8: During an extension cycle, a high extension-error request changes the data to 0x1F.
- R9: An extension request in any other cycle (idle, during a frame, or later than directly after the end byte) is ignored.
- R10: A start byte on the cycle after an end byte, or during an extension, begins a new frame and takes priority over the extension request.
- R11: An error request on a cycle that sends neither a frame byte nor a gap leaves the outputs unchanged, and it sets the sticky flag, which stays 1 until reset.
- R12: Enable 0 with error 1 is driven only with data 0x0F or 0x1F.
- R13: A start marker on a byte inside a frame is treated as an ordinary frame byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte present this cycle |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Stream byte |
| err_req | input | 1 | Propagate an error on this cycle's byte |
| ext_req | input | 1 | Request carrier extension |
| ext_err_req | input | 1 | Send extension as extension-error |
| gtx_en | output | 1 | Transmit enable to the PHY |
| gtx_er | output | 1 | Transmit error to the PHY |
| gtx_d | output | 8 | Transmit data to the PHY |
| stray_err | output | 1 | Sticky: error request seen outside a frame |

## Verification
The frame-tracking state decides each cycle's output code, so a wrong state shows on the pins one clock after the input that exposed it. A lost frame drops enable in the middle of a frame, or turns a gap into idle. A state that wrongly believes a frame has just ended lets a stray extension request drive 0x0F after idle. A missed start leaves enable low while bytes are offered. The bench runs a per-cycle reference model and compares all four outputs on every cycle, so any such mismatch is reported in the cycle it first appears.

// File: rtl/gmii_tx_pkg.sv
package gmii_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_LAST,
    ST_EXT
  } tx_state_e;

  typedef enum logic [2:0] {
    K_IDLE,
    K_DATA,
    K_ERRDATA,
    K_GAP,
    K_EXT,
    K_EXTERR
  } tx_kind_e;
endpackage

// File: rtl/gmii_tx_fsm.sv
module gmii_tx_fsm
  import gmii_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_eof,
  input  logic ext_req,
  output logic send_byte,
  output logic send_gap,
  output logic send_ext
);
  tx_state_e state_q, state_d;
  logic      start;

  always_comb begin
    start     = in_valid && in_sof && (state_q != ST_FRAME);
    send_byte = start || (state_q == ST_FRAME && in_valid);
    send_gap  = (state_q == ST_FRAME) && !in_valid;
    send_ext  = !start && ext_req && (state_q == ST_LAST || state_q == ST_EXT);
    if (send_byte && in_eof)      state_d = ST_LAST;
    else if (send_byte || send_gap) state_d = ST_FRAME;
    else if (send_ext)            state_d = ST_EXT;
    else                          state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/gmii_tx_codegen.sv
module gmii_tx_codegen
  import gmii_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] EXT_CODE     = 8'h0F,
  parameter logic [DATA_W-1:0] EXT_ERR_CODE = 8'h1F
) (
  input  logic              send_byte,
  input  logic              send_gap,
  input  logic              send_ext,
  input  logic              err_req,
  input  logic              ext_err_req,
  input  logic [DATA_W-1:0] in_data,
  output logic              en_nxt,
  output logic              er_nxt,
  output logic [DATA_W-1:0] d_nxt,
  output logic              stray_hit
);
  localparam logic [DATA_W-1:0] IDLE_CODE = '0;
  tx_kind_e kind;

  always_comb begin
    if (send_byte)     kind = err_req ? K_ERRDATA : K_DATA;
    else if (send_gap) kind = K_GAP;
    else if (send_ext) kind = ext_err_req ? K_EXTERR : K_EXT;
    else               kind = K_IDLE;
  end

  always_comb begin
    en_nxt = 1'b0;
    er_nxt = 1'b0;
    d_nxt  = IDLE_CODE;
    case (kind)
      K_DATA:    begin en_nxt = 1'b1; d_nxt = in_data; end
      K_ERRDATA: begin en_nxt = 1'b1; er_nxt = 1'b1; d_nxt = in_data; end
      K_GAP:     begin en_nxt = 1'b1; er_nxt = 1'b1; end
      K_EXT:     begin er_nxt = 1'b1; d_nxt = EXT_CODE; end
      K_EXTERR:  begin er_nxt = 1'b1; d_nxt = EXT_ERR_CODE; end
      default:   ;
    endcase
  end

  assign stray_hit = err_req && !send_byte && !send_gap;
endmodule

// File: rtl/gmii_tx_outreg.sv
module gmii_tx_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_nxt,
  input  logic              er_nxt,
  input  logic [DATA_W-1:0] d_nxt,
  input  logic              stray_hit,
  output logic              gtx_en,
  output logic              gtx_er,
  output logic [DATA_W-1:0] gtx_d,
  output logic              stray_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gtx_en    <= 1'b0;
      gtx_er    <= 1'b0;
      gtx_d     <= '0;
      stray_err <= 1'b0;
    end else begin
      gtx_en    <= en_nxt;
      gtx_er    <= er_nxt;
      gtx_d     <= d_nxt;
      stray_err <= stray_err || stray_hit;
    end
  end
endmodule

// File: rtl/gmii_tx_encoder.sv
module gmii_tx_encoder #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] EXT_CODE     = 8'h0F,
  parameter logic [DATA_W-1:0] EXT_ERR_CODE = 8'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  input  logic              err_req,
  input  logic              ext_req,
  input  logic              ext_err_req,
  output logic              gtx_en,
  output logic              gtx_er,
  output logic [DATA_W-1:0] gtx_d,
  output logic              stray_err
);
  logic              send_byte, send_gap, send_ext;
  logic              en_nxt, er_nxt, stray_hit;
  logic [DATA_W-1:0] d_nxt;

  gmii_tx_fsm i_fsm (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .ext_req   (ext_req),
    .send_byte (send_byte),
    .send_gap  (send_gap),
    .send_ext  (send_ext)
  );

  gmii_tx_codegen #(
    .DATA_W       (DATA_W),
    .EXT_CODE     (EXT_CODE),
    .EXT_ERR_CODE (EXT_ERR_CODE)
  ) i_codegen (
    .send_byte   (send_byte),
    .send_gap    (send_gap),
    .send_ext    (send_ext),
    .err_req     (err_req),
    .ext_err_req (ext_err_req),
    .in_data     (in_data),
    .en_nxt      (en_nxt),
    .er_nxt      (er_nxt),
    .d_nxt       (d_nxt),
    .stray_hit   (stray_hit)
  );

  gmii_tx_outreg #(.DATA_W(DATA_W)) i_outreg (
    .clk       (clk),
    .rst       (rst),
    .en_nxt    (en_nxt),
    .er_nxt    (er_nxt),
    .d_nxt     (d_nxt),
    .stray_hit (stray_hit),
    .gtx_en    (gtx_en),
    .gtx_er    (gtx_er),
    .gtx_d     (gtx_d),
    .stray_err (stray_err)
  );
endmodule

// File: rtl/gmii_tx_encoder_chk.sv
module gmii_tx_encoder_chk #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] EXT_CODE     = 8'h0F,
  parameter logic [DATA_W-1:0] EXT_ERR_CODE = 8'h1F
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic [DATA_W-1:0] in_data,
  input logic              err_req,
  input logic              ext_req,
  input logic              ext_err_req,
  input logic              gtx_en,
  input logic              gtx_er,
  input logic [DATA_W-1:0] gtx_d,
  input logic              stray_err
);
  // R12
  legal_ext_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!gtx_en && gtx_er) |-> (gtx_d == EXT_CODE || gtx_d == EXT_ERR_CODE));

  // R6
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!gtx_en && !gtx_er) |-> (gtx_d == '0));

  // R11
  stray_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stray_err |=> stray_err);

  // R3
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gtx_en) |-> $past(in_valid && in_sof));

  // R9
  ext_follows_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (!gtx_en && gtx_er) |-> $past(gtx_en || gtx_er));

  // R4
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (gtx_en && !$past(in_eof) && !$past(in_valid)) |=> gtx_en || $past(in_eof));
endmodule

bind gmii_tx_encoder gmii_tx_encoder_chk #(
  .DATA_W(DATA_W), .EXT_CODE(EXT_CODE), .EXT_ERR_CODE(EXT_ERR_CODE)
) i_chk (.*);

// File: tb/test_gmii_tx_encoder.sv
module test_gmii_tx_encoder;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          err_req = 1'b0, ext_req = 1'b0, ext_err_req = 1'b0;
  logic          gtx_en, gtx_er, stray_err;
  logic [DW-1:0] gtx_d;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state: 0 idle, 1 frame, 2 just after end, 3 extension
  int unsigned m_state = 0;
  logic        m_stray = 1'b0;

  always #2.5 clk = ~clk;

  gmii_tx_encoder i_gmii_tx_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .err_req(err_req), .ext_req(ext_req), .ext_err_req(ext_err_req),
    .gtx_en(gtx_en), .gtx_er(gtx_er), .gtx_d(gtx_d), .stray_err(stray_err)
  );

  function automatic logic m_start(input int unsigned s, input logic v, input logic sof);
    return v && sof && (s != 1);
  endfunction

  function automatic logic [DW+1:0] exp_out(input int unsigned s, input logic v,
      input logic sof, input logic err, input logic ext, input logic xe, input logic [DW-1:0] d);
    logic st;
    st = m_start(s, v, sof);
    if (st || (s == 1 && v)) return {1'b1, err, d};
    if (s == 1)              return {2'b11, 8'h00};
    if (ext && (s == 2 || s == 3)) return {2'b01, xe ? 8'h1F : 8'h0F};
    return '0;
  endfunction

  function automatic int unsigned next_state(input int unsigned s, input logic v,
      input logic sof, input logic eof, input logic ext);
    logic st, by;
    st = m_start(s, v, sof);
    by = st || (s == 1 && v);
    if (by && eof) return 2;
    if (by || s == 1) return 1;
    if (ext && (s == 2 || s == 3)) return 3;
    return 0;
  endfunction

  function automatic string auto_tag(input logic [DW+1:0] e, input logic xe);
    if (e[DW+1] && e[DW]) return "R5/R4";
    if (e[DW+1]) return "R2";
    if (e[DW]) return xe ? "R8" : "R7";
    return "R6/R9";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic sof, input logic eof, input logic [DW-1:0] d,
      input logic err, input logic ext, input logic xe, input string tag);
    logic [DW+1:0] e;
    logic          es;
    string         t;
    in_valid = v; in_sof = sof; in_eof = eof; in_data = d;
    err_req = err; ext_req = ext; ext_err_req = xe;
    e  = exp_out(m_state, v, sof, err, ext, xe, d);
    es = m_stray || (err && !(m_start(m_state, v, sof) || m_state == 1));
    t  = (tag == "") ? auto_tag(e, xe) : tag;
    @(posedge clk);
    @(negedge clk);
    check({gtx_en, gtx_er, gtx_d} == e, t, {22'd0, gtx_en, gtx_er, gtx_d}, {22'd0, e});
    check(stray_err == es, "R11", {31'd0, stray_err}, {31'd0, es});
    check(!(!gtx_en && gtx_er && gtx_d != 8'h0F && gtx_d != 8'h1F), "R12",
          {22'd0, gtx_en, gtx_er, gtx_d}, 32'h10F);
    m_state = next_state(m_state, v, sof, eof, ext);
    m_stray = es;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check({gtx_en, gtx_er, gtx_d, stray_err} == '0, "R1", {21'd0, gtx_en, gtx_er, gtx_d, stray_err}, 0);
    rst = 1'b0;
    // frame with extension then extension error
    step(1, 1, 0, 8'h55, 0, 1, 0, "R2");
    step(1, 0, 0, 8'hD5, 0, 1, 0, "R9");
    step(1, 0, 0, 8'hA7, 1, 0, 0, "R5");
    step(0, 0, 0, 8'h33, 0, 0, 0, "R4");
    step(1, 1, 0, 8'h44, 0, 0, 0, "R13");
    step(1, 0, 1, 8'hE1, 0, 0, 0, "R4");
    step(0, 0, 0, 8'h00, 0, 1, 0, "R7");
    step(0, 0, 0, 8'h00, 0, 1, 0, "R7");
    step(0, 0, 0, 8'h00, 0, 1, 1, "R8");
    step(0, 0, 0, 8'h00, 0, 0, 0, "R7");
    step(0, 0, 0, 8'h00, 0, 1, 0, "R9");
    // valid without start is ignored
    step(1, 0, 0, 8'h99, 0, 0, 0, "R3");
    // single-byte frame, late extension ignored
    step(1, 1, 1, 8'h12, 0, 0, 0, "R2");
    step(0, 0, 0, 8'h00, 0, 0, 0, "R6");
    step(0, 0, 0, 8'h00, 0, 1, 0, "R9");
    // new start right after end beats extension request
    step(1, 1, 1, 8'h21, 0, 0, 0, "R2");
    step(1, 1, 0, 8'h22, 0, 1, 0, "R10");
    step(1, 0, 1, 8'h23, 0, 0, 0, "R2");
    step(0, 0, 0, 8'h00, 0, 1, 0, "R7");
    step(1, 1, 1, 8'h24, 0, 1, 0, "R10");
    step(0, 0, 0, 8'h00, 0, 0, 0, "R6");
    // stray error request
    step(0, 0, 0, 8'h00, 1, 0, 0, "R11");
    step(0, 0, 0, 8'h00, 0, 0, 0, "R11");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [DW-1:0] rd;
      rd = DW'($urandom);
      step(($urandom % 10) < 8, ($urandom % 10) < 2, ($urandom % 10) < 2, rd,
           ($urandom % 20) == 0, ($urandom % 10) < 5, ($urandom % 10) < 3, "");
    end
    // reset clears the sticky flag
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check({gtx_en, gtx_er, gtx_d, stray_err} == '0, "R1", {21'd0, gtx_en, gtx_er, gtx_d, stray_err}, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule